// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in in one combinational pass. The carries are not passed from bit to bit. Each bit first classifies itself: it kills an incoming carry when both operand bits are 0, passes it on when exactly one bit is 1, and creates one when both bits are 1. The 16 bits form four 4-bit slices. Each slice works out its internal carries straight from those per-bit signals as sums of products. Each slice also reports a slice-level generate and a slice-level propagate.

A second-level unit takes the four slice-level pairs and the external carry-in. From these it forms the carry into every slice and the final carry-out, again as flat sums of products. A parent datapath places the block between its own registers wherever it needs a fast full-width addition. The operand width and the slice width are parameters.

Top module: `cla_adder16`

## Requirements
- R1: When no bit position has both operand bits set and the carry-in is 0, no carry arises anywhere: sum_o equals a_i OR b_i and carry_o is 0.
- R2: Inside a slice, the carry into bit k is the OR of each lower bit's generate ANDed with the propagates of all bits between it and k, plus the slice carry-in ANDed with all propagates below k. Every 4-bit value pair and carry-in in any slice gives the arithmetic result.
- R3: A slice's propagate is the AND of its four bit propagates (bit propagate = a XOR b). Its generate is g3 + p3·g2 + p3·p2·g1 + p3·p2·p1·g0 (bit generate = a AND b). A carry made in or passed through one slice reaches every higher slice that propagates.
- R4: A carry-in of 1 travels the full width when every bit propagates (b_i = ~a_i). The sum is then all zeros and carry_o is 1. With a carry-in of 0 the sum is all ones and carry_o is 0.
- R5: Each sum bit equals that bit's propagate XOR the carry into that bit. A single set bit i in a_i with b_i = 0 gives sum_o = 1<<i, and the same bit set in both gives sum_o = 1<<(i+1), with carry_o = 1 when i = 15.
- R6: carry_o is the carry out of the top slice, formed by the second-level unit. It is 1 when both top operand bits are 1. It is 0 when both are 0.
- R7: For every input, {carry_o, sum_o} equals a_i + b_i + carry_i taken as unsigned 17-bit arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Carry out of bit 15 |

## Verification
The bench sweeps every value of a_i with b_i set to its complement. This is the all-propagate case, where a missing product term in either lookahead level would stop the carry part-way and leave a run of ones above it. Each slice is then driven exhaustively over its 4-bit pair and carry-in, while the other slices propagate. A wrong slice generate or propagate would show up as a wrong carry into the next slice, or a wrong carry_o. Kill-only patterns catch a term that creates a carry where none should exist. Single-bit cases at every position catch a swapped or misaligned sum bit. A long pseudo-random run compares the whole result against plain addition.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Widest operand slice a single lookahead level may be asked to cover.
  localparam int unsigned LA_MAX = 32;

  typedef logic [LA_MAX-1:0] la_vec_t;

  // Carry into position pos, written as a flat sum of products:
  // c0·p[0..pos-1]  +  sum over j<pos of g[j]·p[j+1..pos-1]
  function automatic logic la_carry(input la_vec_t g, input la_vec_t p,
                                    input logic c0, input int unsigned pos);
    logic sop;
    logic term;
    term = c0;
    for (int unsigned k = 0; k < pos; k++) term = term & p[k];
    sop = term;
    for (int unsigned j = 0; j < pos; j++) begin
      term = g[j];
      for (int unsigned k = j + 1; k < pos; k++) term = term & p[k];
      sop = sop | term;
    end
    return sop;
  endfunction

  // AND of the first n propagates.
  function automatic logic la_all_prop(input la_vec_t p, input int unsigned n);
    logic prod;
    prod = 1'b1;
    for (int unsigned k = 0; k < n; k++) prod = prod & p[k];
    return prod;
  endfunction

endpackage

// File: rtl/cla_pg_bit.sv
module cla_pg_bit (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic prop_o
);

  // both ones: create; exactly one: pass; none: kill
  assign gen_o  = a_i & b_i;
  assign prop_o = a_i ^ b_i;

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          carry_i,
  output logic [GW-1:0] sum_o,
  output logic          grp_gen_o,
  output logic          grp_prop_o
);

  logic [GW-1:0] bit_g;
  logic [GW-1:0] bit_p;
  logic [GW-1:0] bit_c;
  la_vec_t       g_ext;
  la_vec_t       p_ext;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    cla_pg_bit u_pg (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .gen_o (bit_g[i]),
      .prop_o(bit_p[i])
    );
  end

  assign g_ext = la_vec_t'(bit_g);
  assign p_ext = la_vec_t'(bit_p);

  // every internal carry straight from g/p, no bit-to-bit chain
  always_comb begin
    for (int unsigned i = 0; i < GW; i++) begin
      bit_c[i] = la_carry(g_ext, p_ext, carry_i, i);
    end
  end

  // slice summary for the second level (generate ignores the slice carry-in)
  assign grp_gen_o  = la_carry(g_ext, p_ext, 1'b0, GW);
  assign grp_prop_o = la_all_prop(p_ext, GW);

  assign sum_o = bit_p ^ bit_c;

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
  import cla_pkg::*;
#(
  parameter int unsigned NG = 4
) (
  input  logic [NG-1:0] grp_gen_i,
  input  logic [NG-1:0] grp_prop_i,
  input  logic          carry_i,
  output logic [NG-1:0] grp_carry_o,
  output logic          carry_o
);

  la_vec_t gg_ext;
  la_vec_t gp_ext;

  assign gg_ext = la_vec_t'(grp_gen_i);
  assign gp_ext = la_vec_t'(grp_prop_i);

  always_comb begin
    for (int unsigned i = 0; i < NG; i++) begin
      grp_carry_o[i] = la_carry(gg_ext, gp_ext, carry_i, i);
    end
  end

  assign carry_o = la_carry(gg_ext, gp_ext, carry_i, NG);

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned GW    = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  localparam int unsigned NG = WIDTH / GW;

  logic [NG-1:0] grp_gen;
  logic [NG-1:0] grp_prop;
  logic [NG-1:0] grp_carry;

  for (genvar s = 0; s < NG; s++) begin : g_slice
    cla_group #(.GW(GW)) u_grp (
      .a_i       (a_i[s*GW +: GW]),
      .b_i       (b_i[s*GW +: GW]),
      .carry_i   (grp_carry[s]),
      .sum_o     (sum_o[s*GW +: GW]),
      .grp_gen_o (grp_gen[s]),
      .grp_prop_o(grp_prop[s])
    );
  end

  cla_carry_unit #(.NG(NG)) u_top_la (
    .grp_gen_i  (grp_gen),
    .grp_prop_i (grp_prop),
    .carry_i    (carry_i),
    .grp_carry_o(grp_carry),
    .carry_o    (carry_o)
  );

endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o
);

  always_comb begin
    // R7
    exact_sum_chk: assert ({carry_o, sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}))
      else $error("R7 result differs from arithmetic sum");

    if (((a_i & b_i) == '0) && !carry_i) begin
      // R1
      kill_only_chk: assert ((sum_o == (a_i | b_i)) && !carry_o)
        else $error("R1 carry appeared without any generate");
    end

    if (b_i == ~a_i) begin
      // R4
      full_chain_chk: assert ((carry_o == carry_i) && (sum_o == {WIDTH{~carry_i}}))
        else $error("R4 carry did not cross the full width");
    end

    if (a_i[WIDTH-1] && b_i[WIDTH-1]) begin
      // R6
      top_gen_chk: assert (carry_o)
        else $error("R6 top generate lost");
    end

    if (!a_i[WIDTH-1] && !b_i[WIDTH-1]) begin
      // R6
      top_kill_chk: assert (!carry_o)
        else $error("R6 top kill ignored");
    end
  end

endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .carry_i(carry_i),
  .sum_o  (sum_o),
  .carry_o(carry_o)
);

// File: tb/sim_cla_adder16.sv
`timescale 1ns/1ps
module sim_cla_adder16;

  logic        clk;
  logic [15:0] a;
  logic [15:0] b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;

  int checks;
  int errors;
  bit done;

  cla_adder16 #(.WIDTH(16), .GW(4)) u0 (
    .a_i    (a),
    .b_i    (b),
    .carry_i(cin),
    .sum_o  (sum),
    .carry_o(cout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // drive after a rising edge, compare at the following falling edge
  task automatic apply(input logic [15:0] av, input logic [15:0] bv,
                       input logic cv, input string tag);
    logic [16:0] exp;
    @(posedge clk);
    #1;
    a   = av;
    b   = bv;
    cin = cv;
    exp = {1'b0, av} + {1'b0, bv} + {16'd0, cv};
    @(negedge clk);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b got %b_%h exp %b_%h",
               tag, av, bv, cv, cout, sum, exp[16], exp[15:0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired after %0d checks, expected completion", checks);
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    a = '0; b = '0; cin = 1'b0;

    // idle inputs give an all-zero result (R7)
    apply(16'h0000, 16'h0000, 1'b0, "R7 idle");

    // R5: single bit positions, plain and doubled
    for (int i = 0; i < 16; i++) begin
      apply(16'h1 << i, 16'h0000, 1'b0, "R5 single bit");
      apply(16'h1 << i, 16'h1 << i, 1'b0, "R5 doubled bit");
    end

    // R6: top-bit generate and kill
    apply(16'h8000, 16'h8000, 1'b0, "R6 top generate");
    apply(16'hFFFF, 16'h0001, 1'b0, "R6 ripple out");
    apply(16'h7FFF, 16'h7FFF, 1'b1, "R6 top kill");

    // R4: every operand paired with its complement, carry-in both ways
    for (int v = 0; v < 65536; v++) begin
      apply(v[15:0], ~v[15:0], v[0] ^ v[5], "R4 full propagate");
    end

    // R2 / R3: each slice exhaustive, other slices propagating
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          for (int c = 0; c < 2; c++) begin
            logic [15:0] av;
            logic [15:0] bv;
            av = 16'h0F0F;
            bv = 16'hF0F0;
            av[s*4 +: 4] = x[3:0];
            bv[s*4 +: 4] = y[3:0];
            apply(av, bv, c[0], "R2 R3 slice sweep");
          end
        end
      end
    end

    // R1: no generate anywhere, carry-in 0
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[15:0], ~lfsr[15:0] & lfsr[31:16], 1'b0, "R1 kill only");
    end

    // R7: pseudo-random operands
    for (int n = 0; n < 30000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[15:0], lfsr[31:16], lfsr[7], "R7 random");
    end

    finish_run();
  end

endmodule